// File: doc/BRIEF.md
# Interconnect Self-Test Launch Sequencer

This block decides when a built-in self-test of the on-chip interconnect may begin, and it controls how the system comes back afterwards. Software writes a 4-bit launch key. The test begins only when that key holds the arming value and the CPU reports that it sits in its wait-for-interrupt idle state. While the test runs, only the CPU is held in reset. The test engine receives a one-cycle start pulse and returns a done pulse together with two pass results.

When the engine reports done, the sequencer does four things:
- it samples the two results into readable status bits;
- it puts the key back to its idle value;
- it holds the interconnect in reset for a fixed window while the CPU stays in reset;
- it raises a fail flag to the error-signaling unit if either result was a failure.

All pins are plain control and status levels or pulses. No data stream crosses the block, so it has no valid/ready back-pressure.

Top module: `stl_launch_seq`

## Requirements
- R1: After reset the key reads 0x5. A key write stores the written 4-bit value as written, and the stored value is readable on `key_rd`.
- R2: A launch happens only when the stored key equals 0xA and `cpu_idle` is high. The key value alone does not launch, and `cpu_idle` alone does not launch.
- R3: Each launch produces `eng_start` high for exactly one cycle, and a launch produces only one such pulse.
- R4: While the test runs, `cpu_rst_hold` is high and `ic_rst` stays low.
- R5: When the engine reports done, the key returns by itself to 0x5.
- R6: After done, `ic_rst` is high for exactly 16 consecutive cycles, and `cpu_rst_hold` stays high through every one of them.
- R7: `neg_ok` and `pos_ok` take the values of `eng_neg_pass` and `eng_pos_pass` at the done pulse, and they hold those values afterwards.
- R8: `st_fail` rises when the post-test reset window ends, if either pass result was low. It then stays high until the next launch clears it.
- R9: An `eng_done` pulse while no test is running changes neither the status bits nor `st_fail`, and it does not assert `ic_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_wr_en | input | 1 | Key field write strobe |
| key_wr_data | input | 4 | Value to write into the key field |
| key_rd | output | 4 | Current key field value |
| cpu_idle | input | 1 | CPU reports wait-for-interrupt idle |
| cpu_rst_hold | output | 1 | Holds the CPU cores in reset |
| ic_rst | output | 1 | Interconnect reset during the post-test window |
| eng_start | output | 1 | One-cycle start pulse to the test engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_neg_pass | input | 1 | Negative-test result, valid with eng_done |
| eng_pos_pass | input | 1 | Positive-test result, valid with eng_done |
| neg_ok | output | 1 | Latched negative-test pass status |
| pos_ok | output | 1 | Latched positive-test pass status |
| st_fail | output | 1 | Self-test failure flag to the error-signaling unit |

## Verification
The assertions check several properties on every cycle:
- a start pulse is one cycle long and follows a cycle in which the CPU was idle;
- the interconnect reset never appears without the CPU reset hold;
- the window counter never passes its limit;
- the key reads 0x5 right after a reload;
- the fail flag rises only as the reset window closes.

Other behaviour can only be shown by the bench's scenarios. These are the exact 16-cycle length of the window, the stored-as-written key values, the refusal to launch on key alone or idle alone, and the capture of the pass results. They also include the fail flag persisting until the next launch and the disregard of stray done pulses.

// File: rtl/stl_pkg.sv
package stl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ARMED      = 3'd1,
    ST_TESTING    = 3'd2,
    ST_POST_RESET = 3'd3,
    ST_DONE       = 3'd4
  } stl_state_e;
endpackage

// File: rtl/stl_key_reg.sv
module stl_key_reg #(
  parameter int          KEY_W    = 4,
  parameter logic [KEY_W-1:0] IDLE_KEY = 4'h5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             reload,
  output logic [KEY_W-1:0] key_q
);
  // reload on completion wins over a coincident software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= IDLE_KEY;
    else if (reload) key_q <= IDLE_KEY;
    else if (wr_en)  key_q <= wr_data;
  end

  p_key_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> key_q == IDLE_KEY);
endmodule

// File: rtl/stl_rst_timer.sv
module stl_rst_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= last ? '0 : cnt_q + 1'b1;
    else          cnt_q <= '0;
  end

  assign last = run && (cnt_q == LAST_CNT);

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_CNT);
endmodule

// File: rtl/stl_fsm.sv
module stl_fsm
  import stl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic key_armed,
  input  logic cpu_idle,
  input  logic eng_done,
  input  logic eng_neg_pass,
  input  logic eng_pos_pass,
  input  logic win_last,
  output logic cpu_rst_hold,
  output logic ic_rst,
  output logic eng_start,
  output logic key_reload,
  output logic neg_ok,
  output logic pos_ok,
  output logic st_fail
);
  stl_state_e state_q, state_d;
  logic       launch;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (key_armed) state_d = ST_ARMED;
      ST_ARMED:      if (!key_armed) state_d = ST_IDLE;
                     else if (cpu_idle) state_d = ST_TESTING;
      ST_TESTING:    if (eng_done) state_d = ST_POST_RESET;
      ST_POST_RESET: if (win_last) state_d = ST_DONE;
      ST_DONE:       state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  assign launch       = (state_q == ST_ARMED) && key_armed && cpu_idle;
  assign key_reload   = (state_q == ST_TESTING) && eng_done;
  assign cpu_rst_hold = (state_q == ST_TESTING) || (state_q == ST_POST_RESET);
  assign ic_rst       = (state_q == ST_POST_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      eng_start <= 1'b0;
      neg_ok    <= 1'b0;
      pos_ok    <= 1'b0;
      st_fail   <= 1'b0;
    end else begin
      state_q   <= state_d;
      eng_start <= launch;
      if (key_reload) begin
        neg_ok <= eng_neg_pass;
        pos_ok <= eng_pos_pass;
      end
      if (launch) st_fail <= 1'b0;
      else if (ic_rst && win_last) st_fail <= !(neg_ok && pos_ok);
    end
  end

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_start) |-> $past(cpu_idle) && $past(key_armed));
  p_fail_at_window_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_fail) |-> $past(state_q == ST_POST_RESET));
  p_status_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_TESTING) |=> $stable(neg_ok) && $stable(pos_ok));
endmodule

// File: rtl/stl_launch_seq.sv
module stl_launch_seq #(
  parameter int               KEY_W       = 4,
  parameter logic [KEY_W-1:0] ARM_KEY     = 4'hA,
  parameter logic [KEY_W-1:0] IDLE_KEY    = 4'h5,
  parameter int               POST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr_en,
  input  logic [KEY_W-1:0] key_wr_data,
  output logic [KEY_W-1:0] key_rd,
  input  logic             cpu_idle,
  output logic             cpu_rst_hold,
  output logic             ic_rst,
  output logic             eng_start,
  input  logic             eng_done,
  input  logic             eng_neg_pass,
  input  logic             eng_pos_pass,
  output logic             neg_ok,
  output logic             pos_ok,
  output logic             st_fail
);
  logic key_reload;
  logic win_last;

  stl_key_reg #(.KEY_W(KEY_W), .IDLE_KEY(IDLE_KEY)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(key_wr_en), .wr_data(key_wr_data),
    .reload(key_reload), .key_q(key_rd)
  );

  stl_rst_timer #(.CYCLES(POST_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(ic_rst), .last(win_last)
  );

  stl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .key_armed(key_rd == ARM_KEY),
    .cpu_idle(cpu_idle), .eng_done(eng_done), .eng_neg_pass(eng_neg_pass),
    .eng_pos_pass(eng_pos_pass), .win_last(win_last),
    .cpu_rst_hold(cpu_rst_hold), .ic_rst(ic_rst), .eng_start(eng_start),
    .key_reload(key_reload), .neg_ok(neg_ok), .pos_ok(pos_ok), .st_fail(st_fail)
  );

  p_ic_under_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ic_rst |-> cpu_rst_hold);
endmodule

// File: tb/tb_stl_launch_seq.sv
module tb_stl_launch_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_wr_en = 1'b0;
  logic [3:0] key_wr_data = 4'h0;
  logic [3:0] key_rd;
  logic cpu_idle = 1'b0;
  logic cpu_rst_hold, ic_rst, eng_start;
  logic eng_done = 1'b0, eng_neg_pass = 1'b0, eng_pos_pass = 1'b0;
  logic neg_ok, pos_ok, st_fail;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  stl_launch_seq dut (
    .clk(clk), .rst_n(rst_n), .key_wr_en(key_wr_en), .key_wr_data(key_wr_data),
    .key_rd(key_rd), .cpu_idle(cpu_idle), .cpu_rst_hold(cpu_rst_hold),
    .ic_rst(ic_rst), .eng_start(eng_start), .eng_done(eng_done),
    .eng_neg_pass(eng_neg_pass), .eng_pos_pass(eng_pos_pass),
    .neg_ok(neg_ok), .pos_ok(pos_ok), .st_fail(st_fail)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_key(input logic [3:0] v);
    @(negedge clk); key_wr_en = 1'b1; key_wr_data = v;
    @(negedge clk); key_wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 key reset", key_rd, 5);
    check("R3 start at reset", eng_start, 0);
    check("R4 cpu hold at reset", cpu_rst_hold, 0);
    check("R8 fail at reset", st_fail, 0);
  endtask

  // R2: key alone and idle alone never launch
  task automatic t_no_launch;
    int starts = 0;
    cpu_idle = 1'b0;
    write_key(4'hA);
    check("R1 key armed readback", key_rd, 10);
    repeat (8) begin @(negedge clk); starts += eng_start; end
    check("R2 key alone starts", starts, 0);
    check("R2 key alone cpu hold", cpu_rst_hold, 0);
    write_key(4'h3);
    check("R1 other key stored", key_rd, 3);
    cpu_idle = 1'b1;
    repeat (8) begin @(negedge clk); starts += eng_start; end
    check("R2 idle alone starts", starts, 0);
    check("R1 key unchanged", key_rd, 3);
    cpu_idle = 1'b0;
  endtask

  task automatic t_run(input logic np, input logic pp);
    int starts = 0, waitc = 0, win = 0, hold_bad = 0;
    write_key(4'hA);
    cpu_idle = 1'b1;
    while (!eng_start && waitc < 10) begin @(negedge clk); waitc++; end
    check("R2 launch seen", eng_start, 1);
    check("R8 fail cleared at launch", st_fail, 0);
    starts = eng_start;
    cpu_idle = 1'b0;
    repeat (3) begin
      @(negedge clk); starts += eng_start;
      check("R4 cpu held in test", cpu_rst_hold, 1);
      check("R4 ic free in test", ic_rst, 0);
    end
    check("R3 one start pulse", starts, 1);
    eng_done = 1'b1; eng_neg_pass = np; eng_pos_pass = pp;
    @(negedge clk);
    eng_done = 1'b0; eng_neg_pass = ~np; eng_pos_pass = ~pp;
    check("R5 key reloaded", key_rd, 5);
    check("R7 neg sampled", neg_ok, np);
    check("R7 pos sampled", pos_ok, pp);
    while (ic_rst && win < 40) begin
      win++; if (!cpu_rst_hold) hold_bad++;
      @(negedge clk);
    end
    check("R6 window length", win, 16);
    check("R6 cpu held in window", hold_bad, 0);
    check("R7 neg held", neg_ok, np);
    check("R7 pos held", pos_ok, pp);
    check("R8 fail flag", st_fail, (np && pp) ? 0 : 1);
    repeat (5) @(negedge clk);
    check("R8 fail persists", st_fail, (np && pp) ? 0 : 1);
    check("R5 key stays idle", key_rd, 5);
  endtask

  // R9: stray done outside a test
  task automatic t_stray_done;
    logic n0, p0, f0;
    n0 = neg_ok; p0 = pos_ok; f0 = st_fail;
    @(negedge clk);
    eng_done = 1'b1; eng_neg_pass = ~n0; eng_pos_pass = ~p0;
    @(negedge clk);
    eng_done = 1'b0;
    check("R9 ic reset untouched", ic_rst, 0);
    repeat (3) @(negedge clk);
    check("R9 neg unchanged", neg_ok, n0);
    check("R9 pos unchanged", pos_ok, p0);
    check("R9 fail unchanged", st_fail, f0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_launch();
    t_run(1'b1, 1'b1);
    t_stray_done();
    t_run(1'b0, 1'b1);
    t_stray_done();
    t_run(1'b1, 1'b0);
    t_run(1'b1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule